// File: doc/BRIEF.md
# Clock Source Fault Supervisor with Fallback Selection

This block watches the activity of the on-chip oscillators and decides which source actually feeds each of three system clock outputs: the CPU clock, the subsystem clock and the auxiliary clock. Software programs a source code for each output. The block passes that code through while the programmed source is healthy, and substitutes a fixed backup while it is not. The backup depends on which source failed. A failed low-frequency crystal is replaced by the internal reference oscillator. A failed high-frequency crystal is replaced by the digitally controlled oscillator.

Three sources are monitored: the low-frequency crystal, the high-frequency crystal and the digitally controlled oscillator. Each has an enable and a one-cycle "activity seen" pulse that is synchronised into the reference clock domain. A monitored source that is enabled but shows no activity for a window of reference cycles raises its fault flag. The flag stays set until software clears it. The substitution stays in place until the source has again run cleanly for a whole window after that clear.

While any flag is set, the block asserts a keep-alive request to the digitally controlled oscillator, and it drives an interrupt that is the OR of the fault flags whose enables are set. The block does not mux clock cells. It only produces the effective source code.

Top module: `clk_failsafe_sel`

## Requirements
- R1: Source codes are 0 low-frequency crystal, 1 high-frequency crystal, 2 digitally controlled oscillator, 3 reference oscillator, 4 very-low-power oscillator. Codes 3 and 4 always pass through unchanged, and codes 5 to 7 resolve to 2.
- R2: An enabled monitored source with no activity pulse for WIN_CYC consecutive reference cycles has its flag set on the next clock edge. Bits 0, 1 and 2 of the per-source vectors belong to the low-frequency crystal, the high-frequency crystal and the oscillator respectively.
- R3: A disabled monitored source never raises its fault flag, whatever its activity input does.
- R4: A fault flag holds until its clear bit is pulsed while the fault condition is absent. A clear that arrives while the condition still holds, or a return of activity without a clear, leaves the flag set.
- R5: An output programmed to code 0 yields code 3 while the low-frequency crystal is not verified.
- R6: An output programmed to code 1 yields code 2 while the high-frequency crystal is not verified.
- R7: A monitored source is verified only after its flag is clear and WIN_CYC consecutive fault-free cycles have passed. This also applies after reset, so fallback is in force from reset until then.
- R8: dco_keep_o is high exactly while any fault flag is set.
- R9: flt_irq_o is the OR of the fault flags masked by flt_ie_i.
- R10: An output programmed to code 2 yields code 2 even while the oscillator's own flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_en_i | input | 3 | Per monitored source enable |
| osc_act_i | input | 3 | Per monitored source activity pulse, synchronised |
| flt_clr_i | input | 3 | Per source fault flag clear request |
| flt_ie_i | input | 3 | Per source interrupt enable |
| sel_cpu_i | input | 3 | Programmed source for the CPU clock |
| sel_sub_i | input | 3 | Programmed source for the subsystem clock |
| sel_aux_i | input | 3 | Programmed source for the auxiliary clock |
| eff_cpu_o | output | 3 | Effective source for the CPU clock |
| eff_sub_o | output | 3 | Effective source for the subsystem clock |
| eff_aux_o | output | 3 | Effective source for the auxiliary clock |
| flt_o | output | 3 | Sticky fault flags |
| flt_irq_o | output | 1 | Combined fault interrupt |
| dco_keep_o | output | 1 | Keep the oscillator running |

## Verification
The assertions check the following on every cycle:
- a flag follows its fault condition one edge later;
- a flag never drops without a clear request;
- a flagged source never reports itself verified;
- no output ever carries the code of a crystal whose flag is set;
- the interrupt never fires without the keep-alive request.

Only the bench scenarios can show the rest:
- the exact length of the timeout window;
- the refusal of a clear while a crystal is still dead;
- the extra window of delay before selection returns after a clear;
- the behaviour of a disabled source;
- the routing of every code on all three outputs in both healthy and faulted states.

// File: rtl/clkfs_pkg.sv
package clkfs_pkg;
  typedef enum logic [2:0] {
    SRC_LFX = 3'd0,
    SRC_HFX = 3'd1,
    SRC_DCO = 3'd2,
    SRC_REF = 3'd3,
    SRC_VLO = 3'd4
  } src_e;

  localparam int NMON    = 3;
  localparam int NOUT    = 3;
  localparam int SEL_W   = 3;
  localparam int MON_LFX = 0;
  localparam int MON_HFX = 1;
  localparam int MON_DCO = 2;
endpackage

// File: rtl/flt_mon.sv
module flt_mon #(
  parameter int WIN_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic act_i,
  input  logic clr_i,
  output logic flag_o,
  output logic ok_o
);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] WIN_V = CW'(WIN_CYC);

  logic [CW-1:0] idle_q, run_q;
  logic          flag_q, cond;

  assign cond = en_i && (idle_q == WIN_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 idle_q <= '0;
    else if (!en_i || act_i)     idle_q <= '0;
    else if (idle_q != WIN_V)    idle_q <= idle_q + 1'b1;
  end

  // sticky: only a clear with the condition gone drops it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= cond | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               run_q <= '0;
    else if (flag_q || cond)   run_q <= '0;
    else if (run_q != WIN_V)   run_q <= run_q + 1'b1;
  end

  assign flag_o = flag_q;
  assign ok_o   = (run_q == WIN_V) && !flag_q;

  // R2
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond |=> flag_q);
  // R4
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  // R7
  no_ok_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |=> !ok_o);
endmodule

// File: rtl/clk_route.sv
module clk_route
  import clkfs_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NMON-1:0]  ok_i,
  output logic [SEL_W-1:0] eff_o
);
  always_comb begin
    case (sel_i)
      SRC_LFX: eff_o = ok_i[MON_LFX] ? SRC_LFX : SRC_REF;
      SRC_HFX: eff_o = ok_i[MON_HFX] ? SRC_HFX : SRC_DCO;
      SRC_DCO: eff_o = SRC_DCO;  // last resort, never replaced
      SRC_REF: eff_o = SRC_REF;
      SRC_VLO: eff_o = SRC_VLO;
      default: eff_o = SRC_DCO;
    endcase
  end
endmodule

// File: rtl/clk_failsafe_sel.sv
module clk_failsafe_sel
  import clkfs_pkg::*;
#(
  parameter int WIN_CYC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NMON-1:0]  osc_en_i,
  input  logic [NMON-1:0]  osc_act_i,
  input  logic [NMON-1:0]  flt_clr_i,
  input  logic [NMON-1:0]  flt_ie_i,
  input  logic [SEL_W-1:0] sel_cpu_i,
  input  logic [SEL_W-1:0] sel_sub_i,
  input  logic [SEL_W-1:0] sel_aux_i,
  output logic [SEL_W-1:0] eff_cpu_o,
  output logic [SEL_W-1:0] eff_sub_o,
  output logic [SEL_W-1:0] eff_aux_o,
  output logic [NMON-1:0]  flt_o,
  output logic             flt_irq_o,
  output logic             dco_keep_o
);
  logic [NMON-1:0]  flag, ok;
  logic [SEL_W-1:0] sel [NOUT];
  logic [SEL_W-1:0] eff [NOUT];

  for (genvar m = 0; m < NMON; m++) begin : g_mon
    flt_mon #(.WIN_CYC(WIN_CYC)) u_mon (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (osc_en_i[m]),
      .act_i  (osc_act_i[m]),
      .clr_i  (flt_clr_i[m]),
      .flag_o (flag[m]),
      .ok_o   (ok[m])
    );
  end

  assign sel[0] = sel_cpu_i;
  assign sel[1] = sel_sub_i;
  assign sel[2] = sel_aux_i;

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    clk_route u_route (
      .sel_i (sel[o]),
      .ok_i  (ok),
      .eff_o (eff[o])
    );
  end

  assign eff_cpu_o  = eff[0];
  assign eff_sub_o  = eff[1];
  assign eff_aux_o  = eff[2];
  assign flt_o      = flag;
  assign flt_irq_o  = |(flag & flt_ie_i);
  assign dco_keep_o = |flag;

  // R5
  no_dead_lfx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag[MON_LFX] |-> (eff_cpu_o != SRC_LFX && eff_sub_o != SRC_LFX && eff_aux_o != SRC_LFX));
  // R6
  no_dead_hfx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag[MON_HFX] |-> (eff_cpu_o != SRC_HFX && eff_sub_o != SRC_HFX && eff_aux_o != SRC_HFX));
  // R8
  irq_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_irq_o |-> dco_keep_o);
endmodule

// File: tb/sim_clk_failsafe_sel.sv
module sim_clk_failsafe_sel;
  localparam int WIN = 16;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [2:0] osc_en_i = 3'b111, osc_act_i = 3'b111, flt_clr_i = '0, flt_ie_i = '0;
  logic [2:0] sel_cpu_i = '0, sel_sub_i = '0, sel_aux_i = '0;
  logic [2:0] eff_cpu_o, eff_sub_o, eff_aux_o, flt_o;
  logic       flt_irq_o, dco_keep_o;
  int n_chk = 0, n_fail = 0;

  // {code, expected healthy, expected with both crystals faulted}
  localparam logic [8:0] VEC [0:7] = '{
    {3'd0, 3'd0, 3'd3}, {3'd1, 3'd1, 3'd2}, {3'd2, 3'd2, 3'd2}, {3'd3, 3'd3, 3'd3},
    {3'd4, 3'd4, 3'd4}, {3'd5, 3'd2, 3'd2}, {3'd6, 3'd2, 3'd2}, {3'd7, 3'd2, 3'd2}};

  clk_failsafe_sel #(.WIN_CYC(WIN)) u0 (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic walk(bit faulted, string req);
    for (int i = 0; i < 8; i++) begin
      sel_cpu_i = VEC[i][8:6];
      sel_sub_i = VEC[(i + 1) % 8][8:6];
      sel_aux_i = VEC[(i + 2) % 8][8:6];
      #1;
      chk(req, eff_cpu_o, faulted ? VEC[i][2:0] : VEC[i][5:3]);
      chk(req, eff_sub_o, faulted ? VEC[(i + 1) % 8][2:0] : VEC[(i + 1) % 8][5:3]);
      chk(req, eff_aux_o, faulted ? VEC[(i + 2) % 8][2:0] : VEC[(i + 2) % 8][5:3]);
      cyc(1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    chk("R8 reset flags", flt_o, 0);
    chk("R8 reset keep", dco_keep_o, 0);
    chk("R9 reset irq", flt_irq_o, 0);
    chk("R7 unverified after reset", eff_cpu_o, 3);
    cyc(WIN + 2);
    chk("R7 verified after window", eff_cpu_o, 0);

    walk(1'b0, "R1/R5/R6 healthy routing");

    // R2: both crystals go silent
    osc_act_i = 3'b100;
    cyc(WIN - 1);
    chk("R2 no flag inside window", flt_o, 0);
    cyc(2);
    chk("R2 flag after window", flt_o, 3'b011);
    chk("R8 keep with fault", dco_keep_o, 1);
    chk("R9 irq masked", flt_irq_o, 0);
    flt_ie_i = 3'b001;
    #1;
    chk("R9 irq enabled", flt_irq_o, 1);
    flt_ie_i = 3'b100;
    #1;
    chk("R9 irq other mask", flt_irq_o, 0);

    walk(1'b1, "R5/R6/R10 faulted routing");

    // R4: clear while still dead
    flt_clr_i = 3'b011;
    cyc(1);
    flt_clr_i = '0;
    cyc(1);
    chk("R4 clear refused", flt_o, 3'b011);
    osc_act_i = 3'b111;
    cyc(3);
    chk("R4 no auto recovery", flt_o, 3'b011);
    flt_clr_i = 3'b011;
    cyc(1);
    flt_clr_i = '0;
    sel_cpu_i = 3'd0;
    sel_sub_i = 3'd1;
    #1;
    chk("R4 clear accepted", flt_o, 0);
    chk("R7 lfx held back", eff_cpu_o, 3);
    chk("R7 hfx held back", eff_sub_o, 2);
    cyc(WIN + 2);
    chk("R7 lfx returns", eff_cpu_o, 0);
    chk("R7 hfx returns", eff_sub_o, 1);

    // R3: disabled source silent
    osc_en_i  = 3'b101;
    osc_act_i = 3'b101;
    cyc(2 * WIN);
    chk("R3 disabled no flag", flt_o, 0);
    osc_en_i  = 3'b111;
    osc_act_i = 3'b111;

    // R10: oscillator itself faults
    osc_act_i = 3'b011;
    sel_cpu_i = 3'd2;
    cyc(WIN + 2);
    chk("R10 dco flag", flt_o, 3'b100);
    chk("R10 dco kept", eff_cpu_o, 2);
    chk("R8 keep on dco fault", dco_keep_o, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule